// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Prioritizer

This block gathers the interrupt causes of a two-channel serial controller and drives one interrupt request toward the CPU. Each channel has three causes:

- **Receive:** a character has arrived.
- **Transmit:** the transmit buffer can accept data.
- **Line status:** a modem or status line changed state, the transmitter underran, or a break was seen.

Each cause latches into a pending bit. A per-cause enable bit decides whether that pending bit may raise the request.

The CPU can work in any of three ways:

- **Vectored:** it asserts an acknowledge and reads an 8-bit vector. The vector is a programmable base with three bits replaced by the code of the winning cause.
- **Non-vectored:** it takes the request line alone.
- **Polled:** it reads the pending bits directly.

Software clears pending bits with a clear command. While a channel's line-status bit is set, the latched levels of that channel's three watched lines are held.

Priority is fixed:

1. Channel A ranks above channel B.
2. Within a channel, receive ranks above transmit, which ranks above line status.

Top module: `sio_irq_prio`

## Requirements
- R1: After reset, all pending bits, all enable bits, the latched line levels, the vector base and the request output are zero.
- R2: A pulse on `rx_evt[c]` or `tx_evt[c]` sets pending bit `3c` or `3c+1` respectively at the next clock edge. The bit then stays set until it is cleared. Bit `3c+2` is the line-status bit, and c=0 is channel A.
- R3: Pending bits latch and are readable on `pend_out` whether or not their enable bit is set. The enable register is loaded from `en_data` when `en_wr` is high and uses the same bit layout as the pending bits.
- R4: `irq` is high exactly when some pending bit and its enable bit are both set. It is driven directly from the registered state, so it falls in the cycle after the clear of the last enabled pending bit.
- R5: The winning cause is the enabled pending bit with the lowest index: A receive, A transmit, A line status, then B receive, B transmit, B line status.
- R6: While `iack` is high, `vec_out` equals the base with bits [3:1] replaced by {channel, type}. Channel is 0 for A and 1 for B. Type is 00 for receive, 01 for transmit and 10 for line status. The code is 111 when no enabled cause is pending. While `iack` is low, `vec_out` is zero.
- R7: Each watched line (CTS, DCD, SYNC per channel) passes through two synchronizing flip-flops. Either a rising or a falling change then sets the channel's line-status bit at the third clock edge after the input changes. `lvl_out[3c+0..2]` holds the latched CTS, DCD and SYNC levels.
- R8: A pulse on `underrun_evt[c]` or `break_evt[c]` sets line-status bit `3c+2` at the next clock edge.
- R9: While a channel's line-status bit is set, its latched levels do not change and its line changes are not detected. Once the bit is cleared, a synchronized level that differs from the held level sets the bit again one edge later.
- R10: When `clr_wr` is high, pending bits selected by `clr_mask` clear at the next edge. A set event for the same bit in the same cycle wins.
- R11: The vector base is loaded from `base_data` when `base_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | 2 | Per-channel received-character pulse |
| tx_evt | input | 2 | Per-channel transmit-buffer-empty pulse |
| underrun_evt | input | 2 | Per-channel transmit underrun pulse |
| break_evt | input | 2 | Per-channel break-detected pulse |
| cts_in | input | 2 | Per-channel clear-to-send line, asynchronous |
| dcd_in | input | 2 | Per-channel carrier-detect line, asynchronous |
| sync_in | input | 2 | Per-channel sync line, asynchronous |
| en_wr | input | 1 | Load enable register |
| en_data | input | 6 | Enable bits, same layout as pending |
| clr_wr | input | 1 | Issue clear command |
| clr_mask | input | 6 | Pending bits to clear |
| base_wr | input | 1 | Load vector base |
| base_data | input | 8 | Vector base value |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request, active high |
| vec_out | output | 8 | Vector during acknowledge, else zero |
| pend_out | output | 6 | Pending bits for polling |
| lvl_out | output | 6 | Latched line levels |

## Verification
The main stimulus is a long stream of random pulses, enables, clear commands and acknowledges, with the watched lines held still. This stream separates a priority encoder that scans in the wrong order, or ignores enables, from a correct one: many pending and enable combinations occur at once. It also exposes a clear that beats a same-cycle set. Directed sequences then toggle single watched lines on channel B, both upward and downward. Sampling one cycle early and then on time distinguishes the two-stage synchronizer from a shorter path. A line that toggles while the status bit is held, followed by a clear, shows the freeze and the re-detection against the held level.

// File: rtl/sio_irq_prio.sv
module sio_irq_prio (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_evt,
  input  logic [1:0] tx_evt,
  input  logic [1:0] underrun_evt,
  input  logic [1:0] break_evt,
  input  logic [1:0] cts_in,
  input  logic [1:0] dcd_in,
  input  logic [1:0] sync_in,
  input  logic       en_wr,
  input  logic [5:0] en_data,
  input  logic       clr_wr,
  input  logic [5:0] clr_mask,
  input  logic       base_wr,
  input  logic [7:0] base_data,
  input  logic       iack,
  output logic       irq,
  output logic [7:0] vec_out,
  output logic [5:0] pend_out,
  output logic [5:0] lvl_out
);
  localparam int NCH  = 2;
  localparam int NSRC = 3 * NCH;

  logic [NSRC-1:0] pend_q, en_q, s1_q, s2_q, lvl_q, set_v, act;
  logic [7:0]      base_q;
  logic [2:0]      code;

  wire [NSRC-1:0] raw = {sync_in[1], dcd_in[1], cts_in[1], sync_in[0], dcd_in[0], cts_in[0]};
  wire [NSRC-1:0] clr = clr_wr ? clr_mask : '0;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      set_v[3*c]   = rx_evt[c];
      set_v[3*c+1] = tx_evt[c];
      set_v[3*c+2] = underrun_evt[c] | break_evt[c] |
                     (!pend_q[3*c+2] && (s2_q[3*c +: 3] != lvl_q[3*c +: 3]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      base_q <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      lvl_q  <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      pend_q <= (pend_q & ~clr) | set_v;
      if (en_wr)   en_q   <= en_data;
      if (base_wr) base_q <= base_data;
      for (int c = 0; c < NCH; c++)
        if (!pend_q[3*c+2]) lvl_q[3*c +: 3] <= s2_q[3*c +: 3];
    end
  end

  assign act = pend_q & en_q;
  assign irq = |act;

  always_comb begin
    code = 3'b111;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) code = {i >= 3, 2'(i % 3)};
  end

  assign vec_out  = iack ? {base_q[7:4], code, base_q[0]} : 8'h00;
  assign pend_out = pend_q;
  assign lvl_out  = lvl_q;

  AST_RX_LATCH:   assert property (@(posedge clk) disable iff (!rst_n) rx_evt[0] |=> pend_out[0]); // R2
  AST_CLR_TAKES:  assert property (@(posedge clk) disable iff (!rst_n)
                    clr_wr && clr_mask[3] && !rx_evt[1] |=> !pend_out[3]); // R10
  AST_LVL_HELD:   assert property (@(posedge clk) disable iff (!rst_n) pend_out[5] |=> $stable(lvl_out[5:3])); // R9
  AST_ACK_CODE:   assert property (@(posedge clk) disable iff (!rst_n) irq && iack |-> vec_out[3:1] != 3'b111); // R6
  AST_NO_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) en_q == '0 |-> !irq); // R3
  AST_EXT_UNDER:  assert property (@(posedge clk) disable iff (!rst_n) underrun_evt[1] |=> pend_out[5]); // R8
endmodule

// File: tb/sio_irq_prio_tb.sv
module sio_irq_prio_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] rx_evt = 0, tx_evt = 0, underrun_evt = 0, break_evt = 0;
  logic [1:0] cts_in = 0, dcd_in = 0, sync_in = 0;
  logic en_wr = 0, clr_wr = 0, base_wr = 0, iack = 0;
  logic [5:0] en_data = 0, clr_mask = 0;
  logic [7:0] base_data = 0;
  logic irq;
  logic [7:0] vec_out;
  logic [5:0] pend_out, lvl_out;

  int checks = 0, failures = 0;
  logic [5:0] m_pend = 0, m_en = 0;
  logic [7:0] m_base = 0;

  always #2.5 clk = ~clk;

  sio_irq_prio u_dut (.*);

  function automatic logic [7:0] exp_vec(input logic [5:0] p, input logic [5:0] e,
                                         input logic [7:0] b, input logic ack);
    logic [2:0] cd = 3'b111;
    for (int i = 5; i >= 0; i--) if (p[i] & e[i]) cd = {i >= 3, 2'(i % 3)};
    return ack ? {b[7:4], cd, b[0]} : 8'h00;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_model();
    chk(pend_out == m_pend, "R2/R8/R10 pending", pend_out, m_pend);
    chk(irq == |(m_pend & m_en), "R3/R4 irq", irq, |(m_pend & m_en));
    chk(vec_out == exp_vec(m_pend, m_en, m_base, iack), "R5/R6/R11 vector",
        vec_out, exp_vec(m_pend, m_en, m_base, iack));
  endtask

  initial begin
    #(5 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk(pend_out == 0 && lvl_out == 0 && !irq, "R1 reset", {pend_out, lvl_out, irq}, 0);
    iack = 1; #1;
    chk(vec_out == 8'h0E, "R1 base zero", vec_out, 8'h0E);
    iack = 0;

    for (int n = 0; n < 3000; n++) begin
      logic [5:0] setv, clrv;
      @(negedge clk);
      check_model();
      rx_evt = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
      tx_evt = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
      underrun_evt = 2'($urandom_range(0, 9) == 0 ? $urandom : 0);
      break_evt = 2'($urandom_range(0, 9) == 0 ? $urandom : 0);
      en_wr = ($urandom_range(0, 7) == 0); en_data = 6'($urandom);
      clr_wr = ($urandom_range(0, 2) == 0); clr_mask = 6'($urandom);
      base_wr = ($urandom_range(0, 15) == 0); base_data = 8'($urandom);
      iack = $urandom_range(0, 1) == 1;
      #1;
      chk(vec_out == exp_vec(m_pend, m_en, m_base, iack), "R6 vector on ack",
          vec_out, exp_vec(m_pend, m_en, m_base, iack));
      setv = {underrun_evt[1] | break_evt[1], tx_evt[1], rx_evt[1],
              underrun_evt[0] | break_evt[0], tx_evt[0], rx_evt[0]};
      clrv = clr_wr ? clr_mask : 6'd0;
      @(posedge clk);
      m_pend = (m_pend & ~clrv) | setv;
      if (en_wr) m_en = en_data;
      if (base_wr) m_base = base_data;
    end

    // directed: R10 same-cycle set beats clear
    @(negedge clk);
    rx_evt = 0; tx_evt = 0; underrun_evt = 0; break_evt = 0; base_wr = 0; iack = 0;
    clr_wr = 1; clr_mask = 6'h3F; en_wr = 1; en_data = 6'h3F;
    @(negedge clk);
    en_wr = 0; clr_wr = 1; clr_mask = 6'h01; rx_evt = 2'b01;
    @(negedge clk);
    rx_evt = 0; clr_wr = 0;
    chk(pend_out == 6'h01, "R10 set wins", pend_out, 6'h01);
    chk(irq, "R4 irq up", irq, 1);
    clr_wr = 1; clr_mask = 6'h01;
    @(negedge clk); clr_wr = 0;
    chk(!irq && pend_out == 0, "R4 irq falls after last clear", irq, 0);

    // directed: R7 rising edge on channel B CTS
    en_wr = 1; en_data = 6'h20; base_wr = 1; base_data = 8'hA1;
    cts_in[1] = 1;
    @(negedge clk); en_wr = 0; base_wr = 0;
    @(negedge clk);
    chk(pend_out[5] == 0, "R7 not before third edge", pend_out[5], 0);
    @(negedge clk);
    chk(pend_out[5] == 1 && lvl_out[3] == 1, "R7 rising change detected", {pend_out[5], lvl_out[3]}, 2'b11);
    iack = 1; #1;
    chk(vec_out == 8'hAD, "R6 B line-status code", vec_out, 8'hAD);
    iack = 0;

    // R9 freeze: toggle DCD while bit held
    dcd_in[1] = 1;
    repeat (4) @(negedge clk);
    chk(lvl_out[5:3] == 3'b001, "R9 levels frozen", lvl_out[5:3], 3'b001);
    clr_wr = 1; clr_mask = 6'h20;
    @(negedge clk); clr_wr = 0;
    chk(pend_out[5] == 0, "R9 cleared", pend_out[5], 0);
    @(negedge clk);
    chk(pend_out[5] == 1 && lvl_out[5:3] == 3'b011, "R9 re-detect held difference",
        {pend_out[5], lvl_out[5:3]}, 4'b1011);

    // R7 falling edge on SYNC after a clean clear
    clr_wr = 1; clr_mask = 6'h20;
    @(negedge clk); clr_wr = 0;
    repeat (3) @(negedge clk);
    chk(pend_out[5] == 0, "R7 quiet when lines steady", pend_out[5], 0);
    sync_in[1] = 1;
    repeat (3) @(negedge clk);
    clr_wr = 1; clr_mask = 6'h20;
    @(negedge clk); clr_wr = 0;
    sync_in[1] = 0;
    repeat (3) @(negedge clk);
    chk(pend_out[5] == 1 && lvl_out[5] == 0, "R7 falling change detected", {pend_out[5], lvl_out[5]}, 2'b10);

    // R5 channel A beats channel B; receive beats line status
    rx_evt = 2'b10; tx_evt = 2'b01;
    en_wr = 1; en_data = 6'h3F;
    @(negedge clk); rx_evt = 0; tx_evt = 0; en_wr = 0; iack = 1; #1;
    chk(vec_out == 8'hA3, "R5 A transmit first", vec_out, 8'hA3);
    clr_wr = 1; clr_mask = 6'h02;
    @(negedge clk); clr_wr = 0; #1;
    chk(vec_out == 8'hA9, "R5 B receive over B status", vec_out, 8'hA9);
    iack = 0; #1;
    chk(vec_out == 8'h00, "R6 zero without ack", vec_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule